// File: doc/BRIEF.md
# Split Shift-Register Transfer Scheduler

This block works with a dual-ported video memory. The serial output register of that memory is divided into two halves. While one half shifts pixels out on the panel clock, the other half can be refilled from the array. The memory sends a one-bit indicator that names the half now driving the serial output. That indicator runs in the panel clock domain. The scheduler brings it into its own clock domain, which is the random-port video clock.

Each time the indicator changes level, in either direction, the scheduler asks the memory sequencer to refill the half that has just gone idle. The request carries the row and column to load from. It stays raised until the sequencer acknowledges it. After every acknowledged transfer, the column pointer moves forward by one half-register of words, so the serial stream continues through the line without a gap. A line pulse moves the pointer back to the start of the next row, and a frame pulse moves it back to row zero. A run enable, which also comes from the panel domain, decides whether indicator changes are acted on. If the indicator changes again while a request is still waiting, a sticky error is raised.

Top module: `split_xfer_sched`

## Requirements
- R1: While `rst` is high, and right after it falls, `xfer_req`, `xfer_half`, `overrun`, `xfer_row` and `xfer_col` are all zero.
- R2: Suppose `run_en` is high. A level change of `half_flag` that is first sampled on rising edge m raises `xfer_req` after rising edge m+2, and no earlier. Both directions of change count.
- R3: `xfer_half` gives the half to reload. That is the level `half_flag` had before the change: 0 means the lower half and 1 means the upper half. It holds steady while a request is waiting.
- R4: Once raised, `xfer_req` stays high until a rising edge on which `xfer_ack` is high. After that edge it falls, unless a new change arrives on the same edge (see R9).
- R5: A transfer is accepted on an edge where `xfer_req` and `xfer_ack` are both high. On each accepted transfer, `xfer_col` advances by HALF_WORDS (default 256), modulo 2^COL_W (default 1024).
- R6: A `new_frame` pulse sets both row and column to 0. Otherwise, a `new_line` pulse sets the column to 0 and increments the row, modulo 2^ROW_W. Both pulses take priority over the column advance from an accepted transfer on the same edge.
- R7: Suppose a change of the flag arrives while `xfer_req` is high and `xfer_ack` is low. Then `overrun` goes high and stays high until reset. The waiting request keeps its half and stays raised.
- R8: Changes of `half_flag` that take effect while the synchronised `run_en` is low are dropped. They raise no request and no `overrun`. They are not replayed when `run_en` returns.
- R9: Suppose a change of the flag arrives on the same edge that a request is acknowledged. Then the new request takes over directly and `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video (random-port) clock |
| rst | input | 1 | Synchronous active-high reset |
| half_flag | input | 1 | Active-half indicator from the serial port (panel domain) |
| run_en | input | 1 | Scheduling enable from the panel domain |
| new_line | input | 1 | Single-cycle pulse: advance to the next row, column 0 |
| new_frame | input | 1 | Single-cycle pulse: back to row 0, column 0 |
| xfer_ack | input | 1 | Sequencer accepts the pending transfer |
| xfer_req | output | 1 | Split transfer requested |
| xfer_half | output | 1 | Half to reload (0 lower, 1 upper) |
| xfer_row | output | ROW_W | Row address of the transfer |
| xfer_col | output | COL_W | Column start of the transfer |
| overrun | output | 1 | Sticky: a change of the flag arrived while a request was still waiting |

## Verification
The hardest case to reach is a flag change that lands on exactly the edge where the sequencer acknowledges the previous request. Here the request must move to the new half without going low and without flagging an overrun. The stimulus holds `xfer_ack` high and toggles `half_flag` on consecutive cycles. This makes every synchronised change coincide with an acknowledge. Next, changes spaced two cycles apart with no acknowledge produce a true overrun. Both cases are compared cycle by cycle against a model that delays the flag through a queue.

// File: rtl/sxs_pkg.sv
`timescale 1ns/1ps
package sxs_pkg;
  // Which half of the serial register a transfer targets.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/sxs_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for level signals crossing from the panel clock.
module sxs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sxs_toggle_det.sv
`timescale 1ns/1ps
// Either-edge detector on the synchronised active-half flag.
module sxs_toggle_det
  import sxs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flag_s,
  input  logic  arm,
  output logic  tog,
  output half_e idle_half
);
  logic flag_d;

  always_ff @(posedge clk) begin
    if (rst) flag_d <= 1'b0;
    else     flag_d <= flag_s;
  end

  // The half that was active before the change is the one now empty.
  assign tog       = arm & (flag_s ^ flag_d);
  assign idle_half = half_e'(flag_d);
endmodule

// File: rtl/sxs_req_ctrl.sv
`timescale 1ns/1ps
// Request/acknowledge holder with overrun detection.
module sxs_req_ctrl
  import sxs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tog,
  input  half_e idle_half,
  input  logic  xfer_ack,
  output logic  xfer_req,
  output half_e xfer_half,
  output logic  overrun,
  output logic  fire
);
  assign fire = xfer_req & xfer_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req  <= 1'b0;
      xfer_half <= HALF_LO;
      overrun   <= 1'b0;
    end else if (tog) begin
      if (xfer_req && !xfer_ack) begin
        overrun <= 1'b1;
      end else begin
        xfer_req  <= 1'b1;
        xfer_half <= idle_half;
      end
    end else if (fire) begin
      xfer_req <= 1'b0;
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> xfer_req);
  p_half_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> $stable(xfer_half));
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  p_rise_needs_tog_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_req) |-> $past(tog));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!tog && !xfer_req) |=> !xfer_req);
endmodule

// File: rtl/sxs_addr_ctr.sv
`timescale 1ns/1ps
// Row / column pointer for split transfers.
module sxs_addr_ctr #(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 10,
  parameter int HALF_WORDS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             new_line,
  input  logic             new_frame,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] STEP    = COL_W'(HALF_WORDS);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  always_ff @(posedge clk) begin
    if (rst || new_frame) begin
      row <= '0;
      col <= '0;
    end else if (new_line) begin
      row <= row + ROW_ONE;
      col <= '0;
    end else if (fire) begin
      col <= col + STEP;
    end
  end

  p_col_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && !new_line && !new_frame) |=> (col == $past(col) + STEP));
  p_frame_zero_r6: assert property (@(posedge clk) disable iff (rst)
    new_frame |=> (row == '0 && col == '0));
  p_line_row_r6: assert property (@(posedge clk) disable iff (rst)
    (new_line && !new_frame) |=> (row == $past(row) + ROW_ONE && col == '0));
endmodule

// File: rtl/split_xfer_sched.sv
`timescale 1ns/1ps
module split_xfer_sched #(
  parameter int ROW_W       = 9,
  parameter int COL_W       = 10,
  parameter int HALF_WORDS  = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_flag,
  input  logic             run_en,
  input  logic             new_line,
  input  logic             new_frame,
  input  logic             xfer_ack,
  output logic             xfer_req,
  output logic             xfer_half,
  output logic [ROW_W-1:0] xfer_row,
  output logic [COL_W-1:0] xfer_col,
  output logic             overrun
);
  import sxs_pkg::*;

  localparam int XW = 2;

  logic [XW-1:0] x_s;
  logic          tog;
  half_e         idle_half;
  half_e         half_q;
  logic          fire;

  sxs_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({run_en, half_flag}),
    .q   (x_s)
  );

  sxs_toggle_det u_tog (
    .clk       (clk),
    .rst       (rst),
    .flag_s    (x_s[0]),
    .arm       (x_s[1]),
    .tog       (tog),
    .idle_half (idle_half)
  );

  sxs_req_ctrl u_req (
    .clk       (clk),
    .rst       (rst),
    .tog       (tog),
    .idle_half (idle_half),
    .xfer_ack  (xfer_ack),
    .xfer_req  (xfer_req),
    .xfer_half (half_q),
    .overrun   (overrun),
    .fire      (fire)
  );

  sxs_addr_ctr #(.ROW_W(ROW_W), .COL_W(COL_W), .HALF_WORDS(HALF_WORDS)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .new_line  (new_line),
    .new_frame (new_frame),
    .row       (xfer_row),
    .col       (xfer_col)
  );

  assign xfer_half = half_q;

  p_ovr_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(xfer_req));
endmodule

// File: tb/split_xfer_sched_tb.sv
`timescale 1ns/1ps
module split_xfer_sched_tb;
  localparam int ROW_W = 9, COL_W = 10, HALF_WORDS = 256;
  localparam int NCOL = 1 << COL_W, NROW = 1 << ROW_W;

  logic clk = 1'b0, rst = 1'b1;
  logic half_flag = 1'b0, run_en = 1'b0, new_line = 1'b0, new_frame = 1'b0, xfer_ack = 1'b0;
  logic xfer_req, xfer_half, overrun;
  logic [ROW_W-1:0] xfer_row;
  logic [COL_W-1:0] xfer_col;

  split_xfer_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .HALF_WORDS(HALF_WORDS)) u_dut (
    .clk(clk), .rst(rst), .half_flag(half_flag), .run_en(run_en),
    .new_line(new_line), .new_frame(new_frame), .xfer_ack(xfer_ack),
    .xfer_req(xfer_req), .xfer_half(xfer_half), .xfer_row(xfer_row),
    .xfer_col(xfer_col), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference model: flag and run delayed through queues.
  int fq[$], rq[$];
  int m_req, m_half, m_ovr, m_row, m_col;

  always @(posedge clk) begin
    int tg, fr;
    if (rst) begin
      fq = '{0, 0, 0, 0}; rq = '{0, 0, 0, 0};
      m_req = 0; m_half = 0; m_ovr = 0; m_row = 0; m_col = 0;
    end else begin
      fq.push_back(int'(half_flag)); void'(fq.pop_front());
      rq.push_back(int'(run_en));    void'(rq.pop_front());
      tg = (fq[1] != fq[0] && rq[1] != 0) ? 1 : 0;
      fr = (m_req != 0 && xfer_ack) ? 1 : 0;
      if (tg != 0) begin
        if (m_req != 0 && !xfer_ack) m_ovr = 1;
        else begin m_req = 1; m_half = fq[0]; end
      end else if (fr != 0) m_req = 0;
      if (new_frame) begin m_row = 0; m_col = 0; end
      else if (new_line) begin m_row = (m_row + 1) % NROW; m_col = 0; end
      else if (fr != 0) m_col = (m_col + HALF_WORDS) % NCOL;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 xfer_req model", int'(xfer_req), m_req);
      chk("R3 xfer_half model", int'(xfer_half), m_half);
      chk("R5 xfer_col model", int'(xfer_col), m_col);
      chk("R6 xfer_row model", int'(xfer_row), m_row);
      chk("R7 overrun model", int'(overrun), m_ovr);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip();
    half_flag = ~half_flag;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int old;
    step(3);
    chk("R1 req in reset", int'(xfer_req), 0);
    chk("R1 col in reset", int'(xfer_col), 0);
    rst = 1'b0;
    step(1);
    chk("R1 req after reset", int'(xfer_req), 0);
    chk("R1 row after reset", int'(xfer_row), 0);
    chk("R1 overrun after reset", int'(overrun), 0);
    run_en = 1'b1;
    step(4);

    // R2 latency, rising direction
    flip(); step(1);
    chk("R2 req after edge m", int'(xfer_req), 0);
    step(1);
    chk("R2 req after edge m+1", int'(xfer_req), 0);
    step(1);
    chk("R2 req after edge m+2", int'(xfer_req), 1);
    chk("R3 idle half lower", int'(xfer_half), 0);
    step(2);
    chk("R4 req held without ack", int'(xfer_req), 1);
    xfer_ack = 1'b1; step(1); xfer_ack = 1'b0;
    chk("R4 req drops after ack", int'(xfer_req), 0);
    chk("R5 col advanced", int'(xfer_col), HALF_WORDS);

    // R2/R3 falling direction, then a run of transfers with varying ack delay (R5 wrap)
    for (int i = 0; i < 7; i++) begin
      flip(); step(3 + (i % 4));
      xfer_ack = 1'b1; step(1); xfer_ack = 1'b0;
      step(2);
    end

    // R6 line and frame
    new_line = 1'b1; step(1); new_line = 1'b0;
    chk("R6 col after line", int'(xfer_col), 0);
    step(1);
    new_line = 1'b1; new_frame = 1'b1; step(1); new_line = 1'b0; new_frame = 1'b0;
    chk("R6 frame beats line", int'(xfer_row), 0);
    new_line = 1'b1; step(1); new_line = 1'b0;
    flip(); step(4);
    xfer_ack = 1'b1; new_line = 1'b1; step(1); xfer_ack = 1'b0; new_line = 1'b0;
    chk("R6 line beats advance", int'(xfer_col), 0);
    chk("R6 row two", int'(xfer_row), 2);
    step(2);

    // R9 change coinciding with ack
    xfer_ack = 1'b1;
    flip(); step(1); flip(); step(1); flip(); step(6);
    chk("R9 no overrun on coinciding ack", int'(overrun), 0);
    xfer_ack = 1'b0; step(2);

    // R8 changes while disabled
    run_en = 1'b0; step(4);
    flip(); step(2); flip(); step(3); flip(); step(6);
    chk("R8 no req while disabled", int'(xfer_req), 0);
    chk("R8 no overrun while disabled", int'(overrun), 0);
    run_en = 1'b1; step(6);
    chk("R8 nothing replayed", int'(xfer_req), 0);

    // R7 overrun
    old = int'(half_flag);
    flip(); step(2); flip(); step(6);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R7 request kept", int'(xfer_req), 1);
    chk("R7 half kept", int'(xfer_half), old);
    xfer_ack = 1'b1; step(1); xfer_ack = 1'b0; step(3);
    chk("R7 overrun sticky", int'(overrun), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule